// File: doc/BRIEF.md
# Inter-Frame-Gap Carrier Deference Controller

This block tells a half-duplex 10 Mb/s Ethernet transmitter when the medium has been quiet long enough for it to start a frame. It watches a carrier-sense input that is already synchronous to the clock. It times the inter-frame gap in bit-time ticks, which arrive as a one-cycle strobe from elsewhere. It raises a gap-complete indication when the gap has elapsed. The state is reported on one flag per state: line busy, first gap phase, second gap phase and gap complete. A transmit process can read these flags and find the controller in any of its states. The gap-complete indication can therefore be immediate or some time away.

The gap is 96 ticks by default. It has two phases of 64 ticks and then 32 ticks. In the default two-part mode, carrier seen during the first phase sends the controller back to line busy, and the whole gap starts again once carrier drops. Carrier seen during the second phase is ignored, which keeps access to the medium fair. When the single-timer select is set, the gap still passes through both phases, but carrier is ignored from the moment the gap starts. With the full-duplex flag set, carrier is ignored in every state.

Top module: `ifg_defer_ctrl`

## Requirements
- R1: In half duplex, carrier high while in the complete state moves the controller to line busy on the next cycle. Line busy holds for as long as carrier stays high.
- R2: In line busy, carrier low (or full duplex) moves the controller to the first gap phase on the next cycle, with the tick count starting from zero.
- R3: The first phase ends on its PH1_TICKS-th tick (default 64) and the second phase on its PH2_TICKS-th tick (default 32). Only cycles with bit_tick_i high count, so with a tick every cycle the complete flag appears 1+PH1_TICKS+PH2_TICKS cycles after carrier falls.
- R4: With single_mode_i low and half duplex, carrier high in any cycle of the first phase returns the controller to line busy on the next cycle. This takes priority over the phase ending, and a full gap is timed again after carrier falls.
- R5: Carrier high during the second phase is ignored: the gap completes on the same cycle as with no carrier.
- R6: With single_mode_i high, carrier is ignored in both phases and the full gap of PH1_TICKS+PH2_TICKS ticks runs to completion.
- R7: Reset puts the controller in the complete state with the tick count cleared. gap_done_o is high exactly when the complete state flag is high.
- R8: With full_duplex_i high, carrier never moves the controller to line busy. If full duplex is set while in line busy, the gap starts on the next cycle.
- R9: Exactly one of the four state flags is high in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| carrier_i | input | 1 | Carrier sense, already synchronous to clk_i |
| single_mode_i | input | 1 | 1 = single fixed gap timer, 0 = two-part deferral |
| full_duplex_i | input | 1 | 1 = full duplex; carrier is ignored |
| bit_tick_i | input | 1 | One-cycle strobe per bit time |
| gap_done_o | output | 1 | Gap complete; transmission may start |
| st_busy_o | output | 1 | State flag: line busy |
| st_ph1_o | output | 1 | State flag: first gap phase |
| st_ph2_o | output | 1 | State flag: second gap phase |
| st_done_o | output | 1 | State flag: gap complete |

## Verification
The hardest situations to reach are carrier arriving on the exact tick that ends the first phase, and carrier arriving on the first tick of the second phase. One decides whether the gap restarts and the other must leave the gap untouched. The stimulus reaches both by counting ticks from the fall of carrier and placing one-cycle carrier pulses on each side of the phase boundary. This is done with a tick every cycle and again with a tick every third cycle. A behavioural model compares all five outputs with the block on every cycle. Directed latency checks confirm the 97-cycle gap after a restart and after ignored carrier.

// File: rtl/defer_pkg.sv
package defer_pkg;

  typedef enum logic [1:0] {
    ST_BUSY = 2'd0,
    ST_PH1  = 2'd1,
    ST_PH2  = 2'd2,
    ST_DONE = 2'd3
  } defer_state_e;

  localparam int unsigned NUM_STATES = 4;

  // Number of ticks a state lasts; zero for untimed states.
  function automatic int unsigned phase_ticks(defer_state_e s,
                                              int unsigned p1,
                                              int unsigned p2);
    case (s)
      ST_PH1:  return p1;
      ST_PH2:  return p2;
      default: return 0;
    endcase
  endfunction

  // Carrier takes the medium (idle -> busy) only in half duplex.
  function automatic logic carrier_seizes(logic car, logic fdx);
    return car & ~fdx;
  endfunction

  // Carrier restarts the gap only in the first phase of two-part mode.
  function automatic logic carrier_restarts(logic car, logic single, logic fdx);
    return car & ~single & ~fdx;
  endfunction

  // Line busy releases when carrier drops or carrier is being ignored.
  function automatic logic line_released(logic car, logic fdx);
    return ~car | fdx;
  endfunction

endpackage

// File: rtl/defer_gap_timer.sv
module defer_gap_timer #(
  parameter int unsigned CNT_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             count_en_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;

  assign expire_o = count_en_i && (cnt_q == (limit_i - CNT_W'(1)));

  always_ff @(posedge clk_i) begin
    if (!rst_ni)         cnt_q <= '0;
    else if (clear_i)    cnt_q <= '0;
    else if (count_en_i) cnt_q <= cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/defer_next_state.sv
module defer_next_state
  import defer_pkg::*;
(
  input  defer_state_e state_i,
  input  logic         carrier_i,
  input  logic         single_i,
  input  logic         fdx_i,
  input  logic         expire_i,
  output defer_state_e state_o,
  output logic         restart_ev_o,
  output logic         gap_start_ev_o
);
  always_comb begin
    state_o        = state_i;
    restart_ev_o   = 1'b0;
    gap_start_ev_o = 1'b0;
    case (state_i)
      ST_DONE: if (carrier_seizes(carrier_i, fdx_i)) state_o = ST_BUSY;
      ST_BUSY: if (line_released(carrier_i, fdx_i)) begin
        state_o        = ST_PH1;
        gap_start_ev_o = 1'b1;
      end
      ST_PH1: begin
        if (carrier_restarts(carrier_i, single_i, fdx_i)) begin
          state_o      = ST_BUSY;
          restart_ev_o = 1'b1;
        end else if (expire_i) begin
          state_o = ST_PH2;
        end
      end
      ST_PH2: if (expire_i) state_o = ST_DONE;
      default: state_o = ST_DONE;
    endcase
  end
endmodule

// File: rtl/ifg_defer_ctrl.sv
module ifg_defer_ctrl
  import defer_pkg::*;
#(
  parameter int unsigned PH1_TICKS = 64,
  parameter int unsigned PH2_TICKS = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic carrier_i,
  input  logic single_mode_i,
  input  logic full_duplex_i,
  input  logic bit_tick_i,
  output logic gap_done_o,
  output logic st_busy_o,
  output logic st_ph1_o,
  output logic st_ph2_o,
  output logic st_done_o
);
  localparam int unsigned LONGEST = (PH1_TICKS > PH2_TICKS) ? PH1_TICKS : PH2_TICKS;
  localparam int unsigned CNT_W   = $clog2(LONGEST + 1);

  defer_state_e state_q, state_d;
  logic             in_gap;
  logic             tick_in_gap;
  logic             phase_expire;
  logic             timer_clear;
  logic             restart_ev;
  logic             gap_start_ev;
  logic [CNT_W-1:0] phase_limit;
  logic [NUM_STATES-1:0] st_vec;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) state_q <= ST_DONE;
    else         state_q <= state_d;
  end

  assign in_gap      = (state_q == ST_PH1) || (state_q == ST_PH2);
  assign tick_in_gap = bit_tick_i & in_gap;
  assign phase_limit = CNT_W'(phase_ticks(state_q, PH1_TICKS, PH2_TICKS));
  assign timer_clear = (state_d != state_q);

  defer_gap_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (timer_clear),
    .count_en_i (tick_in_gap),
    .limit_i    (phase_limit),
    .expire_o   (phase_expire)
  );

  defer_next_state u_next (
    .state_i        (state_q),
    .carrier_i      (carrier_i),
    .single_i       (single_mode_i),
    .fdx_i          (full_duplex_i),
    .expire_i       (phase_expire),
    .state_o        (state_d),
    .restart_ev_o   (restart_ev),
    .gap_start_ev_o (gap_start_ev)
  );

  for (genvar i = 0; i < NUM_STATES; i++) begin : g_flag
    assign st_vec[i] = (state_q == defer_state_e'(i));
  end

  assign st_busy_o  = st_vec[ST_BUSY];
  assign st_ph1_o   = st_vec[ST_PH1];
  assign st_ph2_o   = st_vec[ST_PH2];
  assign st_done_o  = st_vec[ST_DONE];
  assign gap_done_o = st_vec[ST_DONE];
endmodule

// File: rtl/defer_ctrl_checker.sv
module defer_ctrl_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic carrier_i,
  input logic single_mode_i,
  input logic full_duplex_i,
  input logic bit_tick_i,
  input logic gap_done_o,
  input logic st_busy_o,
  input logic st_ph1_o,
  input logic st_ph2_o,
  input logic st_done_o,
  input logic restart_ev,
  input logic gap_start_ev
);
  a_r9_one_state: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({st_busy_o, st_ph1_o, st_ph2_o, st_done_o}) == 1);

  a_r1_seize: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_done_o && carrier_i && !full_duplex_i |=> st_busy_o);

  a_r1_busy_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_busy_o && carrier_i && !full_duplex_i |=> st_busy_o);

  a_r2_gap_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gap_start_ev |=> st_ph1_o);

  a_r4_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_ph1_o && carrier_i && !single_mode_i && !full_duplex_i |=> st_busy_o);

  a_r4_restart_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_ev |-> st_ph1_o && carrier_i);

  a_r5_ph2_no_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_ph2_o |=> !st_busy_o);

  a_r6_single_no_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_ph1_o && single_mode_i |=> !st_busy_o);

  a_r8_fdx_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_done_o && full_duplex_i |=> st_done_o);

  a_r3_ph1_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_ph1_o && !bit_tick_i && !restart_ev |=> st_ph1_o);

  a_r3_ph2_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_ph2_o && !bit_tick_i |=> st_ph2_o);

  a_r7_done_out: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gap_done_o == st_done_o);
endmodule

bind ifg_defer_ctrl defer_ctrl_checker u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .carrier_i     (carrier_i),
  .single_mode_i (single_mode_i),
  .full_duplex_i (full_duplex_i),
  .bit_tick_i    (bit_tick_i),
  .gap_done_o    (gap_done_o),
  .st_busy_o     (st_busy_o),
  .st_ph1_o      (st_ph1_o),
  .st_ph2_o      (st_ph2_o),
  .st_done_o     (st_done_o),
  .restart_ev    (restart_ev),
  .gap_start_ev  (gap_start_ev)
);

// File: tb/sim_ifg_defer_ctrl.sv
`timescale 1ns/1ps
module sim_ifg_defer_ctrl;
  localparam int P1 = 64;
  localparam int P2 = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic car = 1'b0, single = 1'b0, fdx = 1'b0, tick = 1'b0;
  logic done_o, busy_o, ph1_o, ph2_o, stdone_o;

  int checks = 0, failures = 0, cycles = 0;
  int tick_every = 1, tick_phase = 0;
  string cur_req = "R7";

  always #2.5 clk = ~clk;

  ifg_defer_ctrl #(.PH1_TICKS(P1), .PH2_TICKS(P2)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .carrier_i(car), .single_mode_i(single),
    .full_duplex_i(fdx), .bit_tick_i(tick), .gap_done_o(done_o),
    .st_busy_o(busy_o), .st_ph1_o(ph1_o), .st_ph2_o(ph2_o), .st_done_o(stdone_o));

  // Reference model: a state name plus ticks still owed in the current phase.
  string m_state = "DONE";
  int    m_left  = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_state = "DONE"; m_left = 0;
    end else if (m_state == "DONE") begin
      if (car && !fdx) m_state = "BUSY";
    end else if (m_state == "BUSY") begin
      if (fdx || !car) begin m_state = "PH1"; m_left = P1; end
    end else if (m_state == "PH1") begin
      if (car && !single && !fdx) m_state = "BUSY";
      else if (tick) begin
        m_left--;
        if (m_left == 0) begin m_state = "PH2"; m_left = P2; end
      end
    end else begin
      if (tick) begin
        m_left--;
        if (m_left == 0) m_state = "DONE";
      end
    end
  end

  task automatic chk(bit ok, string req, int act, int exp, string what);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int flags_of(string s);
    case (s)
      "BUSY": return 4'b0001;
      "PH1":  return 4'b0010;
      "PH2":  return 4'b0100;
      default: return 4'b1000;
    endcase
  endfunction

  // One cycle: compare at the falling edge, then drive the tick for the next edge.
  task automatic step();
    int act, exp;
    @(negedge clk);
    act = {28'd0, stdone_o, ph2_o, ph1_o, busy_o};
    exp = flags_of(m_state);
    if (rst_n) begin
      chk(act == exp, cur_req, act, exp, "state flags vs model");
      chk(done_o == stdone_o, "R7", int'(done_o), int'(stdone_o), "gap_done vs flag");
      chk($countones(act) == 1, "R9", act, 0, "one-hot flags");
    end
    tick_phase = (tick_phase + 1) % tick_every;
    tick = (tick_phase == 0);
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic wait_done(output int n);
    n = 0;
    do begin step(); n++; end while (!stdone_o && n < 2000);
  endtask

  // Step until the given number of ticks have been driven.
  task automatic run_ticks(int k);
    int seen = 0;
    while (seen < k) begin
      if (tick) seen++;
      step();
    end
  endtask

  initial begin
    int n;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    tick = 1'b1;
    @(negedge clk);
    cur_req = "R7";
    chk(stdone_o && done_o && !busy_o && !ph1_o && !ph2_o, "R7", int'(stdone_o), 1, "reset state");

    // R1: carrier seizes the idle line and holds it
    cur_req = "R1";
    car = 1; step();
    chk(busy_o == 1, "R1", int'(busy_o), 1, "busy after carrier");
    run(10);
    chk(busy_o == 1, "R1", int'(busy_o), 1, "busy held");

    // R2/R3: full gap with a tick every cycle
    cur_req = "R3";
    car = 0; wait_done(n);
    chk(n == 1 + P1 + P2, "R3", n, 1 + P1 + P2, "gap latency, tick each cycle");

    // R4: carrier mid first phase restarts the gap
    cur_req = "R4";
    car = 1; step(); car = 0; step();
    chk(ph1_o == 1, "R2", int'(ph1_o), 1, "first phase after carrier drop");
    run_ticks(30);
    car = 1; step();
    chk(busy_o == 1, "R4", int'(busy_o), 1, "restart to busy");
    car = 0; wait_done(n);
    chk(n == 1 + P1 + P2, "R4", n, 1 + P1 + P2, "full gap after restart");

    // R4 boundary: carrier on the last tick of phase one
    car = 1; step(); car = 0;
    run_ticks(P1 - 1);
    car = 1; step();
    chk(busy_o == 1, "R4", int'(busy_o), 1, "restart on last phase-one tick");
    car = 0; run(2);

    // R5: carrier on the first tick of phase two and later is ignored
    cur_req = "R5";
    wait_done(n);
    car = 1; step(); car = 0; step();
    run_ticks(P1);
    chk(ph2_o == 1, "R5", int'(ph2_o), 1, "in second phase");
    car = 1; run(10); car = 0;
    wait_done(n);
    chk(n == P2 - 10, "R5", n, P2 - 10, "gap unchanged by carrier in phase two");
    car = 0; step();

    // R6: single timer ignores carrier throughout
    cur_req = "R6";
    single = 1;
    car = 1; step(); car = 0; step();
    run_ticks(5);
    car = 1; run(20);
    chk(busy_o == 0, "R6", int'(busy_o), 0, "no restart in single mode");
    car = 0; wait_done(n);
    chk(n == 1 + P1 + P2 - 1 - 25, "R6", n, P1 + P2 - 25, "single gap runs out");
    single = 0; step();

    // R3 with sparse ticks and restart pulses around the boundary
    cur_req = "R3";
    tick_every = 3;
    car = 1; step(); car = 0; step();
    run_ticks(P1 - 1);
    car = 1; step(); car = 0;
    run_ticks(P1);
    car = 1; step(); car = 0;
    wait_done(n);
    chk(stdone_o == 1, "R3", int'(stdone_o), 1, "sparse-tick gap completes");
    tick_every = 1;

    // R8: full duplex ignores carrier; fdx during busy starts the gap
    cur_req = "R8";
    car = 1; step();
    fdx = 1; step();
    chk(ph1_o == 1, "R8", int'(ph1_o), 1, "fdx releases busy");
    run(20);
    chk(ph1_o == 1, "R8", int'(ph1_o), 1, "fdx carrier no restart");
    wait_done(n);
    run(10);
    chk(stdone_o == 1, "R8", int'(stdone_o), 1, "fdx idle ignores carrier");
    fdx = 0; car = 0; step();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000) begin
      checks++; failures++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 200000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule